// File: doc/BRIEF.md
# Zone Permission Override Unit

This block sits beside a page translation lookup. It holds a 32-bit register of sixteen 2-bit zone codes, and it turns the rights stored in a translation entry into the rights that an access actually gets. Each translation entry names one of the zones. Depending on the code stored for that zone and on whether the processor is in user or privileged mode, the block takes one of three actions. It can pass the entry's valid, writable and executable bits through unchanged. It can revoke the page completely. It can force the page to be writable and executable.

Software reaches the register through a special-register port. The port has a select address, a write strobe, write data and combinational read data. On every cycle the block also takes the current access kind and reports whether the access is denied. The number of implemented zones is a parameter. Zones above that number hold no storage, and pages that name them are never overridden.

Top module: `zone_guard_top`

## Requirements
- R1: While reset is held, and directly after it, the register reads back as 0x00000000.
- R2: The register is written only when sr_we is 1 and sr_addr equals 0x1001. sr_rdata is 0 whenever sr_addr differs from 0x1001, and a strobe at any other address leaves the register unchanged.
- R3: A write changes the register at the next rising clock edge. A permission lookup made in the same cycle as the write still sees the old contents.
- R4: Zone k is held in register bits [31-2k:30-2k]. Zone 0 therefore sits in the two most significant bits and zone 15 in the two least significant bits.
- R5: In user mode (user_mode=1), code 00 drives eff_v, eff_wr and eff_ex to 0 and raises acc_denied, whatever the entry holds.
- R6: In user mode, codes 01 and 10 pass the entry's valid, writable and executable bits to the outputs unchanged.
- R7: In user mode, code 11 sets eff_wr and eff_ex to 1, and eff_v still follows tlb_v.
- R8: In privileged mode (user_mode=0), codes 00 and 01 pass the entry's bits unchanged. Codes 10 and 11 set eff_wr and eff_ex to 1 with eff_v following tlb_v. Privileged mode never revokes a page.
- R9: With parameter ZONES (1 to 16), zones at index ZONES and above read as 0 and ignore writes. A page whose zone index is ZONES or more behaves as code 01.
- R10: acc_kind is encoded as 0 read, 1 write, 2 execute, 3 probe. acc_denied is 1 when eff_v is 0, when a write meets eff_wr=0, or when an execute meets eff_ex=0. A read or a probe needs only eff_v.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_addr | input | ADDR_W | Special-register select address |
| sr_we | input | 1 | Special-register write strobe |
| sr_wdata | input | 32 | Special-register write data |
| sr_rdata | output | 32 | Special-register read data (0 when not selected) |
| tlb_v | input | 1 | Valid bit from the translation entry |
| tlb_wr | input | 1 | Writable bit from the translation entry |
| tlb_ex | input | 1 | Executable bit from the translation entry |
| tlb_zone | input | 4 | Zone index from the translation entry |
| user_mode | input | 1 | 1 = user mode, 0 = privileged mode |
| acc_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 probe |
| eff_v | output | 1 | Effective valid |
| eff_wr | output | 1 | Effective writable |
| eff_ex | output | 1 | Effective executable |
| acc_denied | output | 1 | Access refused |

## Verification
The assertions assume that the translation inputs and the mode bit are steady around each rising edge and are never X once reset is released. The bench meets this by changing every input one time unit after an edge and only ever driving known values. The assertions also assume that the register can change only through the select port. The stimulus therefore mixes strobes at the selected address, strobes at other addresses and idle cycles, so that both the write and hold paths are exercised. The zone index is drawn over all sixteen values while the bench builds the unit with fewer implemented zones, so the indices that fall outside the implemented range are covered as well.

// File: rtl/zg_pkg.sv
package zg_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_PROBE = 2'd3
  } acc_t;

  typedef struct packed {
    logic v;
    logic wr;
    logic ex;
  } perm_t;

  localparam int MAX_ZONES = 16;
  localparam int WORD_W    = 32;

  // Low bit index of zone k inside the register word.
  function automatic int zone_lsb(input int k);
    return WORD_W - 2 - 2 * k;
  endfunction

  // Register bits that hold storage for the implemented zones.
  function automatic logic [WORD_W-1:0] impl_mask(input int zones);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int k = 0; k < MAX_ZONES; k++)
      if (k < zones) m[zone_lsb(k) +: 2] = 2'b11;
    return m;
  endfunction

  // Effective rights after the zone code is applied.
  function automatic perm_t apply_zone(input logic [1:0] code, input logic user,
                                       input perm_t p);
    perm_t r;
    r = p;
    if (user && code == 2'b00) begin
      r = '0;
    end else if (code == 2'b11 || (!user && code == 2'b10)) begin
      r.wr = 1'b1;
      r.ex = 1'b1;
    end
    return r;
  endfunction

  function automatic logic refuse(input perm_t p, input acc_t a);
    return !p.v || (a == ACC_WRITE && !p.wr) || (a == ACC_EXEC && !p.ex);
  endfunction

endpackage

// File: rtl/zg_zone_reg.sv
module zg_zone_reg
  import zg_pkg::*;
#(
  parameter int ZONES    = 16,
  parameter int ADDR_W   = 14,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 14'h1001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sr_addr,
  input  logic              sr_we,
  input  logic [31:0]       sr_wdata,
  output logic [31:0]       sr_rdata,
  output logic [31:0]       zone_word
);

  localparam logic [31:0] MASK = impl_mask(ZONES);

  logic sel_hit;
  logic wr_hit;

  assign sel_hit = (sr_addr == SEL_ADDR);
  assign wr_hit  = sel_hit && sr_we;

  for (genvar k = 0; k < MAX_ZONES; k++) begin : g_zone
    localparam int LSB = zone_lsb(k);
    if (k < ZONES) begin : g_impl
      logic [1:0] field_q;
      always_ff @(posedge clk) begin
        if (!rst_n)      field_q <= 2'b00;
        else if (wr_hit) field_q <= sr_wdata[LSB+1:LSB];
      end
      assign zone_word[LSB+1:LSB] = field_q;
    end else begin : g_absent
      assign zone_word[LSB+1:LSB] = 2'b00;
    end
  end

  assign sr_rdata = sel_hit ? zone_word : 32'd0;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> zone_word == 32'd0); // R1
  AST_HOLD_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && $past(rst_n)) |=> $stable(zone_word)); // R2
  AST_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> zone_word == ($past(sr_wdata) & MASK)); // R3
  AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rdata & ~MASK) == 32'd0); // R9

endmodule

// File: rtl/zg_zone_perm.sv
module zg_zone_perm
  import zg_pkg::*;
#(
  parameter int ZONES = 16
) (
  input  logic [31:0] zone_word,
  input  perm_t       tlb_perm,
  input  logic [3:0]  tlb_zone,
  input  logic        user_mode,
  input  acc_t        acc_kind,
  output perm_t       eff_perm,
  output logic        denied,
  output logic [1:0]  zone_code,
  output logic        out_of_range
);

  assign out_of_range = int'(tlb_zone) >= ZONES;

  always_comb begin
    zone_code = 2'b01;
    for (int k = 0; k < MAX_ZONES; k++)
      if (k < ZONES && tlb_zone == 4'(k)) zone_code = zone_word[zone_lsb(k) +: 2];
  end

  assign eff_perm = apply_zone(zone_code, user_mode, tlb_perm);
  assign denied   = refuse(eff_perm, acc_kind);

endmodule

// File: rtl/zone_guard_top.sv
module zone_guard_top
  import zg_pkg::*;
#(
  parameter int ZONES  = 16,
  parameter int ADDR_W = 14,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 14'h1001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sr_addr,
  input  logic              sr_we,
  input  logic [31:0]       sr_wdata,
  output logic [31:0]       sr_rdata,
  input  logic              tlb_v,
  input  logic              tlb_wr,
  input  logic              tlb_ex,
  input  logic [3:0]        tlb_zone,
  input  logic              user_mode,
  input  logic [1:0]        acc_kind,
  output logic              eff_v,
  output logic              eff_wr,
  output logic              eff_ex,
  output logic              acc_denied
);

  logic [31:0] zone_word;
  perm_t       tlb_perm;
  perm_t       eff_perm;
  logic [1:0]  zone_code;
  logic        out_of_range;
  logic        revoke_hit;
  logic        force_hit;

  zg_zone_reg #(.ZONES(ZONES), .ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR)) reg_i (
    .clk(clk), .rst_n(rst_n), .sr_addr(sr_addr), .sr_we(sr_we),
    .sr_wdata(sr_wdata), .sr_rdata(sr_rdata), .zone_word(zone_word)
  );

  assign tlb_perm = '{v: tlb_v, wr: tlb_wr, ex: tlb_ex};

  zg_zone_perm #(.ZONES(ZONES)) perm_i (
    .zone_word(zone_word), .tlb_perm(tlb_perm), .tlb_zone(tlb_zone),
    .user_mode(user_mode), .acc_kind(acc_t'(acc_kind)), .eff_perm(eff_perm),
    .denied(acc_denied), .zone_code(zone_code), .out_of_range(out_of_range)
  );

  assign eff_v  = eff_perm.v;
  assign eff_wr = eff_perm.wr;
  assign eff_ex = eff_perm.ex;

  // Named events for the checks below.
  assign revoke_hit = user_mode && zone_code == 2'b00;
  assign force_hit  = zone_code[1] && (zone_code[0] || !user_mode);

  AST_REVOKE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    revoke_hit |-> (!eff_v && !eff_wr && !eff_ex && acc_denied)); // R5
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (!revoke_hit && !force_hit) |-> (eff_v == tlb_v && eff_wr == tlb_wr && eff_ex == tlb_ex)); // R6
  AST_FORCE_RWX: assert property (@(posedge clk) disable iff (!rst_n)
    force_hit |-> (eff_wr && eff_ex && eff_v == tlb_v)); // R7
  AST_PRIV_KEEP_V: assert property (@(posedge clk) disable iff (!rst_n)
    !user_mode |-> eff_v == tlb_v); // R8
  AST_RANGE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_range |-> (eff_v == tlb_v && eff_wr == tlb_wr && eff_ex == tlb_ex)); // R9
  AST_INVALID_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    !eff_v |-> acc_denied); // R10

endmodule

// File: tb/zone_guard_top_tb_top.sv
module zone_guard_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NZ = 12;
  localparam logic [13:0] SEL = 14'h1001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] sr_addr = '0;
  logic        sr_we = 1'b0;
  logic [31:0] sr_wdata = '0;
  logic [31:0] sr_rdata;
  logic        tlb_v = 1'b0, tlb_wr = 1'b0, tlb_ex = 1'b0;
  logic [3:0]  tlb_zone = '0;
  logic        user_mode = 1'b0;
  logic [1:0]  acc_kind = '0;
  logic        eff_v, eff_wr, eff_ex, acc_denied;

  int checks = 0;
  int errors = 0;
  logic [31:0] mreg = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zone_guard_top #(.ZONES(NZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .sr_addr(sr_addr), .sr_we(sr_we),
    .sr_wdata(sr_wdata), .sr_rdata(sr_rdata), .tlb_v(tlb_v), .tlb_wr(tlb_wr),
    .tlb_ex(tlb_ex), .tlb_zone(tlb_zone), .user_mode(user_mode),
    .acc_kind(acc_kind), .eff_v(eff_v), .eff_wr(eff_wr), .eff_ex(eff_ex),
    .acc_denied(acc_denied)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference model: compares every output in the current cycle.
  task automatic check_now();
    int code, ev, ew, ee, ed;
    string tag, rtag;
    logic [31:0] erd;
    if (int'(tlb_zone) >= NZ) code = 1;
    else code = int'((mreg >> (30 - 2 * int'(tlb_zone))) & 32'd3);
    ev = int'(tlb_v); ew = int'(tlb_wr); ee = int'(tlb_ex);
    if (user_mode) begin
      if (code == 0) begin ev = 0; ew = 0; ee = 0; end
      else if (code == 3) begin ew = 1; ee = 1; end
    end else if (code >= 2) begin
      ew = 1; ee = 1;
    end
    ed = (ev == 0) || (acc_kind == 2'd1 && ew == 0) || (acc_kind == 2'd2 && ee == 0);
    if (sr_we && sr_addr == SEL) tag = "R3";          // lookup uses pre-write value
    else if (int'(tlb_zone) >= NZ) tag = "R9";
    else if (!user_mode) tag = "R8";
    else if (code == 0) tag = "R5";
    else if (code == 3) tag = "R7";
    else tag = "R6";
    cmp(tag, "eff_v", int'(eff_v), ev);
    cmp(tag, "eff_wr", int'(eff_wr), ew);
    cmp(tag, "eff_ex", int'(eff_ex), ee);
    cmp("R10", "acc_denied", int'(acc_denied), ed);
    erd = (sr_addr == SEL) ? mreg : 32'd0;
    if (!rst_n) rtag = "R1";
    else if (sr_addr != SEL) rtag = "R2";
    else rtag = "R4";
    cmp(rtag, "sr_rdata", int'(sr_rdata), int'(erd));
  endtask

  task automatic step(input logic we, input logic [13:0] a, input logic [31:0] d,
                      input logic [2:0] vwe, input logic [3:0] z, input logic u,
                      input logic [1:0] k);
    logic [31:0] mask;
    @(posedge clk);
    mask = '0;
    for (int i = 0; i < NZ; i++) mask = mask | (32'h3 << (30 - 2 * i));
    if (!rst_n) mreg = '0;
    else if (sr_we && sr_addr == SEL) mreg = sr_wdata & mask;
    #1;
    sr_we = we; sr_addr = a; sr_wdata = d;
    {tlb_v, tlb_wr, tlb_ex} = vwe;
    tlb_zone = z; user_mode = u; acc_kind = k;
    @(negedge clk);
    check_now();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    // R1: reset state, even with a write strobe present
    step(1'b1, SEL, 32'hFFFF_FFFF, 3'b111, 4'd0, 1'b1, 2'd0);
    step(1'b0, SEL, 32'h0, 3'b111, 4'd0, 1'b1, 2'd0);
    rst_n = 1'b1;
    step(1'b0, SEL, 32'h0, 3'b111, 4'd0, 1'b1, 2'd0);
    cmp("R1", "post-reset read", int'(sr_rdata), 0);
    // R2: write at a wrong address must be ignored
    step(1'b1, 14'h1000, 32'hFFFF_FFFF, 3'b101, 4'd1, 1'b1, 2'd1);
    step(1'b0, SEL, 32'h0, 3'b101, 4'd1, 1'b1, 2'd1);
    cmp("R2", "no write at other addr", int'(sr_rdata), 0);
    // R3: write and same-cycle lookup (model checks the old value)
    step(1'b1, SEL, 32'hFFFF_FFFF, 3'b100, 4'd2, 1'b1, 2'd2);
    step(1'b0, SEL, 32'h0, 3'b100, 4'd2, 1'b1, 2'd2);
    cmp("R9", "absent fields read zero", int'(sr_rdata), int'(32'hFFFF_FF00));
    // R4: only zone 5 set to 11
    step(1'b1, SEL, 32'h3 << 20, 3'b100, 4'd5, 1'b1, 2'd1);
    step(1'b0, SEL, 32'h0, 3'b100, 4'd5, 1'b1, 2'd1);
    cmp("R4", "zone5 forced write", int'(eff_wr), 1);
    step(1'b0, SEL, 32'h0, 3'b111, 4'd4, 1'b1, 2'd0);
    cmp("R5", "zone4 revoked", int'(acc_denied), 1);
    // R9: out-of-range zone acts as no override even in user mode
    step(1'b0, SEL, 32'h0, 3'b110, 4'd14, 1'b1, 2'd2);
    cmp("R9", "zone14 pass deny exec", int'(acc_denied), 1);
    // Random traffic across modes, codes and access kinds
    for (int n = 0; n < 4000; n++) begin
      logic we;
      logic [13:0] a;
      we = ($urandom_range(0, 3) == 0);
      a  = ($urandom_range(0, 1) == 0) ? SEL : 14'($urandom);
      step(we, a, $urandom, 3'($urandom), 4'($urandom), 1'($urandom),
           2'($urandom));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule